// File: doc/BRIEF.md
# HDMI PLL divider search engine

This block chooses the clock-synthesis settings for a display link from a single input: the symbol clock rate in kHz. When started, it scans a fixed set of total divisor values against three oscillator centre frequencies. For each pairing it forms the oscillator frequency as divisor × 5 × symbol clock. It then keeps the pairing whose deviation from its centre is smallest, within an asymmetric tolerance window.

Once the scan has picked a divisor, the engine splits it into three cascaded ratios: a first stage, a middle stage and a last stage. It also converts the chosen oscillator frequency into an integer word and a 15-bit fractional word, both relative to a 24 MHz reference. A controller starts the engine, waits for `done_o`, and reads the held result fields. If `fail_o` is set, the pixel rate cannot be produced.

Top module: `pll_div_search`

## Requirements
- R1: After reset `busy_o`, `done_o` and `fail_o` are low and every result field reads zero.
- R2: A `start_i` pulse seen while idle raises `busy_o` from the next cycle. The search ends with `done_o` high for exactly one cycle, and `busy_o` is low in that same cycle. The result fields hold their values until the next completion.
- R3: Deviation is floor(1000 × |dco − centre| / centre). The best value starts at 60, and a candidate replaces it only when its deviation is strictly smaller. The scan order is centres 8 400 000, 9 000 000, 9 600 000 kHz in the outer loop and divisors in ascending list order in the inner loop, so on a tie the earliest candidate wins.
- R4: A candidate whose dco lies above its centre qualifies only when its deviation is below 10. A candidate at or below its centre qualifies only when its deviation is below the current best.
- R5: The even divisor list (4 to 98, 36 values) is scanned over all three centres first. The odd list {3,5,7,9,15,21,35} is scanned only when no even divisor was chosen.
- R6: When neither list yields a divisor, `fail_o` is high together with `done_o`, and all result fields are zero.
- R7: For an even divisor D with H = D/2 the ratios (first, middle, last) are chosen by the first rule that matches:
  - H ∈ {2,3,5} gives (2,1,H);
  - H even gives (2,H/2,2);
  - H divisible by 3 gives (3,H/3,2);
  - H divisible by 7 gives (7,H/7,2).
- R8: The odd divisors map as follows: 3→(3,1,1), 5→(5,1,1), 7→(7,1,1), 9→(3,1,3), 15→(3,1,5), 21→(7,1,3), 35→(7,1,5).
- R9: `mid_en_o` is high exactly when the middle ratio differs from 1.
- R10: `dco_khz_o` equals divisor × 5 × symbol clock. `centre_sel_o` encodes the winning centre as 0 = 8 400 000 kHz, 1 = 9 000 000 kHz and 2 = 9 600 000 kHz.
- R11: `dco_int_o` = floor(dco / 24000). With a = floor(dco × 32768 / 24), `dco_frac_o` = floor((a − dco_int × 32 768 000) / 1000).
- R12: The single-cycle quotient variant and the bit-serial quotient variant produce identical results for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (accepted while idle) |
| sym_khz_i | input | SYM_W | Symbol clock in kHz, held during the search |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | No divisor found (valid with done_o) |
| div_o | output | DIV_W | Chosen total divisor |
| pdiv_o | output | 3 | First-stage ratio |
| mid_o | output | P1_W | Middle-stage ratio |
| kdiv_o | output | 3 | Last-stage ratio |
| mid_en_o | output | 1 | Middle stage in use |
| centre_sel_o | output | 2 | Winning centre code |
| dco_khz_o | output | DCO_W | Oscillator frequency in kHz |
| dco_int_o | output | INT_W | Integer word relative to 24 MHz |
| dco_frac_o | output | FRAC_W | Fractional word |

## Verification
The bench targets the edge of the upper tolerance. At 141 300 kHz the deviation above 8.4 GHz is 9, which must win. At 141 400 kHz it is exactly 10, which must lose to a deviation of 57 below 9 GHz; a design with the wrong comparison picks the wrong centre. The bench also drives rates where only an odd divisor fits (250, 340 and 540 MHz) and rates where nothing fits. A design that searched odd and even together, or that failed to flag the empty case, would return the wrong divisor or a spurious result. Random rates cover ties, the factor rules and the fraction arithmetic, and each result from the bit-serial quotient build is compared with the single-cycle build.

// File: rtl/pds_pkg.sv
package pds_pkg;

   localparam int CEN_W = 24;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_EVAL = 2'd1,
      ST_DIV  = 2'd2,
      ST_CALC = 2'd3
   } pds_state_e;

   function automatic logic [6:0] even_div(input logic [5:0] idx);
      logic [6:0] v;
      case (idx)
         6'd0:  v = 7'd4;   6'd1:  v = 7'd6;   6'd2:  v = 7'd8;   6'd3:  v = 7'd10;
         6'd4:  v = 7'd12;  6'd5:  v = 7'd14;  6'd6:  v = 7'd16;  6'd7:  v = 7'd18;
         6'd8:  v = 7'd20;  6'd9:  v = 7'd24;  6'd10: v = 7'd28;  6'd11: v = 7'd30;
         6'd12: v = 7'd32;  6'd13: v = 7'd36;  6'd14: v = 7'd40;  6'd15: v = 7'd42;
         6'd16: v = 7'd44;  6'd17: v = 7'd48;  6'd18: v = 7'd52;  6'd19: v = 7'd54;
         6'd20: v = 7'd56;  6'd21: v = 7'd60;  6'd22: v = 7'd64;  6'd23: v = 7'd66;
         6'd24: v = 7'd68;  6'd25: v = 7'd70;  6'd26: v = 7'd72;  6'd27: v = 7'd76;
         6'd28: v = 7'd78;  6'd29: v = 7'd80;  6'd30: v = 7'd84;  6'd31: v = 7'd88;
         6'd32: v = 7'd90;  6'd33: v = 7'd92;  6'd34: v = 7'd96;  6'd35: v = 7'd98;
         default: v = 7'd0;
      endcase
      return v;
   endfunction

   function automatic logic [6:0] odd_div(input logic [5:0] idx);
      logic [6:0] v;
      case (idx)
         6'd0: v = 7'd3;  6'd1: v = 7'd5;  6'd2: v = 7'd7;  6'd3: v = 7'd9;
         6'd4: v = 7'd15; 6'd5: v = 7'd21; 6'd6: v = 7'd35;
         default: v = 7'd0;
      endcase
      return v;
   endfunction

   function automatic logic [CEN_W-1:0] centre_khz(input logic [1:0] sel);
      logic [CEN_W-1:0] v;
      case (sel)
         2'd0:    v = CEN_W'(8400000);
         2'd1:    v = CEN_W'(9000000);
         default: v = CEN_W'(9600000);
      endcase
      return v;
   endfunction

endpackage

// File: rtl/pds_dev_div.sv
module pds_dev_div #(
   parameter int NUM_W     = 40,
   parameter int DEN_W     = 24,
   parameter int Q_W       = 6,
   parameter bit ITERATIVE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [Q_W-1:0]   quot_o,
   output logic             valid_o
);
   localparam int CW = (Q_W > 1) ? $clog2(Q_W) : 1;

   if (NUM_W < DEN_W + Q_W) begin : g_bad_w
      $error("pds_dev_div: NUM_W too small for shifted divisor");
   end

   if (ITERATIVE) begin : g_serial
      logic [NUM_W-1:0] rem_q;
      logic [DEN_W-1:0] den_q;
      logic [CW-1:0]    bit_q;
      logic             run_q;
      logic [Q_W-1:0]   quot_q;
      logic             vld_q;
      logic [NUM_W-1:0] trial;

      assign trial = NUM_W'(den_q) << bit_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            rem_q  <= '0;
            den_q  <= '0;
            bit_q  <= '0;
            run_q  <= 1'b0;
            quot_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= 1'b0;
            if (start_i) begin
               rem_q  <= num_i;
               den_q  <= den_i;
               bit_q  <= CW'(Q_W - 1);
               quot_q <= '0;
               run_q  <= 1'b1;
            end else if (run_q) begin
               if (rem_q >= trial) begin
                  rem_q         <= rem_q - trial;
                  quot_q[bit_q] <= 1'b1;
               end
               if (bit_q == '0) begin
                  run_q <= 1'b0;
                  vld_q <= 1'b1;
               end else begin
                  bit_q <= bit_q - 1'b1;
               end
            end
         end
      end

      assign quot_o  = quot_q;
      assign valid_o = vld_q;
   end else begin : g_flat
      logic [NUM_W-1:0] full;
      logic [Q_W-1:0]   quot_q;
      logic             vld_q;

      assign full = num_i / NUM_W'(den_i);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            quot_q <= '0;
            vld_q  <= 1'b0;
         end else begin
            vld_q <= start_i;
            if (start_i) quot_q <= full[Q_W-1:0];
         end
      end

      assign quot_o  = quot_q;
      assign valid_o = vld_q;
   end

endmodule

// File: rtl/pds_factor.sv
module pds_factor #(
   parameter int DIV_W = 7,
   parameter int P1_W  = 5
) (
   input  logic [DIV_W-1:0] div_i,
   output logic [2:0]       pdiv_o,
   output logic [P1_W-1:0]  mid_o,
   output logic [2:0]       kdiv_o
);
   logic [DIV_W-1:0] half;
   logic [DIV_W-1:0] by2, by3, by7;

   assign half = div_i >> 1;
   assign by2  = half >> 1;
   assign by3  = half / DIV_W'(3);
   assign by7  = half / DIV_W'(7);

   always_comb begin
      pdiv_o = 3'd1;
      mid_o  = P1_W'(1);
      kdiv_o = 3'd1;
      if (!div_i[0]) begin
         if (half == DIV_W'(2) || half == DIV_W'(3) || half == DIV_W'(5)) begin
            pdiv_o = 3'd2;
            kdiv_o = half[2:0];
         end else if (!half[0]) begin
            pdiv_o = 3'd2;
            mid_o  = by2[P1_W-1:0];
            kdiv_o = 3'd2;
         end else if (half % DIV_W'(3) == '0) begin
            pdiv_o = 3'd3;
            mid_o  = by3[P1_W-1:0];
            kdiv_o = 3'd2;
         end else if (half % DIV_W'(7) == '0) begin
            pdiv_o = 3'd7;
            mid_o  = by7[P1_W-1:0];
            kdiv_o = 3'd2;
         end
      end else begin
         case (div_i)
            DIV_W'(3):  pdiv_o = 3'd3;
            DIV_W'(5):  pdiv_o = 3'd5;
            DIV_W'(7):  pdiv_o = 3'd7;
            DIV_W'(9):  begin pdiv_o = 3'd3; kdiv_o = 3'd3; end
            DIV_W'(15): begin pdiv_o = 3'd3; kdiv_o = 3'd5; end
            DIV_W'(21): begin pdiv_o = 3'd7; kdiv_o = 3'd3; end
            DIV_W'(35): begin pdiv_o = 3'd7; kdiv_o = 3'd5; end
            default:    pdiv_o = 3'd1;
         endcase
      end
   end

endmodule

// File: rtl/pds_dco_words.sv
module pds_dco_words #(
   parameter int DCO_W  = 30,
   parameter int INT_W  = 10,
   parameter int FRAC_W = 15
) (
   input  logic [DCO_W-1:0]  dco_i,
   output logic [INT_W-1:0]  int_o,
   output logic [FRAC_W-1:0] frac_o
);
   localparam int X_W = DCO_W + FRAC_W + 12;

   logic [X_W-1:0] d_x, int_x, a_x, b_x, f_x;

   assign d_x   = X_W'(dco_i);
   assign int_x = d_x / X_W'(24000);
   assign a_x   = (d_x << FRAC_W) / X_W'(24);
   assign b_x   = int_x * (X_W'(1000) << FRAC_W);
   assign f_x   = (a_x - b_x) / X_W'(1000);

   assign int_o  = int_x[INT_W-1:0];
   assign frac_o = f_x[FRAC_W-1:0];

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
   import pds_pkg::*;
#(
   parameter int SYM_W         = 20,
   parameter int DIV_W         = 7,
   parameter int DEV_W         = 6,
   parameter int DEV_START     = 60,
   parameter int ABOVE_LIM     = 10,
   parameter int P1_W          = 5,
   parameter int INT_W         = 10,
   parameter int FRAC_W        = 15,
   parameter bit DIV_ITERATIVE = 1'b1,
   localparam int AFE_W        = SYM_W + 3,
   localparam int DCO_W        = AFE_W + DIV_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [SYM_W-1:0]  sym_khz_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [2:0]        pdiv_o,
   output logic [P1_W-1:0]   mid_o,
   output logic [2:0]        kdiv_o,
   output logic              mid_en_o,
   output logic [1:0]        centre_sel_o,
   output logic [DCO_W-1:0]  dco_khz_o,
   output logic [INT_W-1:0]  dco_int_o,
   output logic [FRAC_W-1:0] dco_frac_o
);
   localparam int NUM_W     = DCO_W + 10;
   localparam int EVEN_LAST = 35;
   localparam int ODD_LAST  = 6;

   if (DIV_W < 7) begin : g_chk_div
      $error("pll_div_search: DIV_W must hold divisor 98");
   end
   if (DEV_START >= (1 << DEV_W) || ABOVE_LIM > DEV_START) begin : g_chk_dev
      $error("pll_div_search: deviation limits do not fit DEV_W");
   end
   if (P1_W < 5) begin : g_chk_p1
      $error("pll_div_search: P1_W must hold middle ratio 24");
   end

   pds_state_e         state_q;
   logic [AFE_W-1:0]   afe_q;
   logic               par_q;
   logic [1:0]         cidx_q;
   logic [5:0]         didx_q;
   logic [DEV_W-1:0]   best_q;
   logic               found_q;
   logic [DIV_W-1:0]   bdiv_q;
   logic [1:0]         bcen_q;

   // candidate evaluation
   logic [DIV_W-1:0]   cand_div;
   logic [CEN_W-1:0]   cand_cen;
   logic [DCO_W-1:0]   cand_dco;
   logic [DCO_W-1:0]   diff;
   logic               above;
   logic [DEV_W-1:0]   lim;
   logic [NUM_W-1:0]   num;
   logic               accept;
   logic               dv_start;
   logic [DEV_W-1:0]   dv_q;
   logic               dv_valid;
   logic               advance;
   logic               found_n;
   logic               last_div;

   assign cand_div = par_q ? DIV_W'(odd_div(didx_q)) : DIV_W'(even_div(didx_q));
   assign cand_cen = centre_khz(cidx_q);
   assign cand_dco = DCO_W'(cand_div) * DCO_W'(afe_q);
   assign above    = cand_dco > DCO_W'(cand_cen);
   assign diff     = above ? (cand_dco - DCO_W'(cand_cen)) : (DCO_W'(cand_cen) - cand_dco);
   assign lim      = (above && (best_q > DEV_W'(ABOVE_LIM))) ? DEV_W'(ABOVE_LIM) : best_q;
   assign num      = NUM_W'(diff) * NUM_W'(1000);
   assign accept   = num < (NUM_W'(lim) * NUM_W'(cand_cen));

   assign dv_start = (state_q == ST_EVAL) && accept;
   assign advance  = ((state_q == ST_EVAL) && !accept) || ((state_q == ST_DIV) && dv_valid);
   assign found_n  = found_q || ((state_q == ST_DIV) && dv_valid);
   assign last_div = par_q ? (didx_q == 6'(ODD_LAST)) : (didx_q == 6'(EVEN_LAST));

   pds_dev_div #(
      .NUM_W     (NUM_W),
      .DEN_W     (CEN_W),
      .Q_W       (DEV_W),
      .ITERATIVE (DIV_ITERATIVE)
   ) u_dev (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (dv_start),
      .num_i   (num),
      .den_i   (cand_cen),
      .quot_o  (dv_q),
      .valid_o (dv_valid)
   );

   // result formation from the winning divisor
   logic [DCO_W-1:0]  best_dco;
   logic [2:0]        f_p0, f_p2;
   logic [P1_W-1:0]   f_p1;
   logic [INT_W-1:0]  w_int;
   logic [FRAC_W-1:0] w_frac;

   assign best_dco = DCO_W'(bdiv_q) * DCO_W'(afe_q);

   pds_factor #(.DIV_W(DIV_W), .P1_W(P1_W)) u_fac (
      .div_i  (bdiv_q),
      .pdiv_o (f_p0),
      .mid_o  (f_p1),
      .kdiv_o (f_p2)
   );

   pds_dco_words #(.DCO_W(DCO_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_words (
      .dco_i  (best_dco),
      .int_o  (w_int),
      .frac_o (w_frac)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         afe_q        <= '0;
         par_q        <= 1'b0;
         cidx_q       <= '0;
         didx_q       <= '0;
         best_q       <= DEV_W'(DEV_START);
         found_q      <= 1'b0;
         bdiv_q       <= '0;
         bcen_q       <= '0;
         done_o       <= 1'b0;
         fail_o       <= 1'b0;
         div_o        <= '0;
         pdiv_o       <= '0;
         mid_o        <= '0;
         kdiv_o       <= '0;
         mid_en_o     <= 1'b0;
         centre_sel_o <= '0;
         dco_khz_o    <= '0;
         dco_int_o    <= '0;
         dco_frac_o   <= '0;
      end else begin
         done_o <= 1'b0;
         fail_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  afe_q   <= AFE_W'(sym_khz_i) * AFE_W'(5);
                  par_q   <= 1'b0;
                  cidx_q  <= '0;
                  didx_q  <= '0;
                  best_q  <= DEV_W'(DEV_START);
                  found_q <= 1'b0;
                  bdiv_q  <= '0;
                  bcen_q  <= '0;
                  state_q <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (accept) state_q <= ST_DIV;
            end
            ST_DIV: begin
               if (dv_valid) begin
                  best_q  <= dv_q;
                  bdiv_q  <= cand_div;
                  bcen_q  <= cidx_q;
                  found_q <= 1'b1;
               end
            end
            ST_CALC: begin
               state_q <= ST_IDLE;
               done_o  <= 1'b1;
               fail_o  <= !found_q;
               if (found_q) begin
                  div_o        <= bdiv_q;
                  pdiv_o       <= f_p0;
                  mid_o        <= f_p1;
                  kdiv_o       <= f_p2;
                  mid_en_o     <= (f_p1 != P1_W'(1));
                  centre_sel_o <= bcen_q;
                  dco_khz_o    <= best_dco;
                  dco_int_o    <= w_int;
                  dco_frac_o   <= w_frac;
               end else begin
                  div_o        <= '0;
                  pdiv_o       <= '0;
                  mid_o        <= '0;
                  kdiv_o       <= '0;
                  mid_en_o     <= 1'b0;
                  centre_sel_o <= '0;
                  dco_khz_o    <= '0;
                  dco_int_o    <= '0;
                  dco_frac_o   <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase

         if (advance) begin
            state_q <= ST_EVAL;
            if (last_div) begin
               didx_q <= '0;
               if (cidx_q == 2'd2) begin
                  cidx_q <= '0;
                  if (found_n || par_q) state_q <= ST_CALC;
                  else                  par_q   <= 1'b1;
               end else begin
                  cidx_q <= cidx_q + 2'd1;
               end
            end else begin
               didx_q <= didx_q + 6'd1;
            end
         end
      end
   end

   assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
   parameter int DIV_W = 7,
   parameter int P1_W  = 5
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic             fail_o,
   input logic [DIV_W-1:0] div_o,
   input logic [2:0]       pdiv_o,
   input logic [P1_W-1:0]  mid_o,
   input logic [2:0]       kdiv_o,
   input logic [1:0]       centre_sel_o
);
   AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o); // R2
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R2
   AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy_o); // R2
   AST_FAIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fail_o |-> (done_o && div_o == '0)); // R6
   AST_RATIO_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !fail_o) |-> (32'(pdiv_o) * 32'(mid_o) * 32'(kdiv_o) == 32'(div_o))); // R7
   AST_ODD_NO_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && !fail_o && div_o[0]) |-> (mid_o == P1_W'(1))); // R8
   AST_CENTRE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (centre_sel_o != 2'd3)); // R10
   AST_RESULTS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!done_o && busy_o) |-> $stable(div_o)); // R2
endmodule

bind pll_div_search pds_checker #(.DIV_W(DIV_W), .P1_W(P1_W)) u_pds_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .start_i      (start_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .fail_o       (fail_o),
   .div_o        (div_o),
   .pdiv_o       (pdiv_o),
   .mid_o        (mid_o),
   .kdiv_o       (kdiv_o),
   .centre_sel_o (centre_sel_o)
);

// File: tb/pll_div_search_tb_top.sv
module pll_div_search_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SYM_W = 20;
   localparam int DCO_W = SYM_W + 3 + 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [SYM_W-1:0] sym = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   logic i_busy, i_done, i_fail, i_men, f_busy, f_done, f_fail, f_men;
   logic [6:0] i_div, f_div;
   logic [2:0] i_p0, i_p2, f_p0, f_p2;
   logic [4:0] i_p1, f_p1;
   logic [1:0] i_cen, f_cen;
   logic [DCO_W-1:0] i_dco, f_dco;
   logic [9:0] i_int, f_int;
   logic [14:0] i_frac, f_frac;

   pll_div_search dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sym_khz_i(sym),
      .busy_o(i_busy), .done_o(i_done), .fail_o(i_fail), .div_o(i_div),
      .pdiv_o(i_p0), .mid_o(i_p1), .kdiv_o(i_p2), .mid_en_o(i_men),
      .centre_sel_o(i_cen), .dco_khz_o(i_dco), .dco_int_o(i_int), .dco_frac_o(i_frac));

   pll_div_search #(.DIV_ITERATIVE(1'b0)) dut_f (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sym_khz_i(sym),
      .busy_o(f_busy), .done_o(f_done), .fail_o(f_fail), .div_o(f_div),
      .pdiv_o(f_p0), .mid_o(f_p1), .kdiv_o(f_p2), .mid_en_o(f_men),
      .centre_sel_o(f_cen), .dco_khz_o(f_dco), .dco_int_o(f_int), .dco_frac_o(f_frac));

   int tests = 0;
   int fails = 0;

   int even_l [0:35] = '{4,6,8,10,12,14,16,18,20,24,28,30,32,36,40,42,44,48,52,54,
                         56,60,64,66,68,70,72,76,78,80,84,88,90,92,96,98};
   int odd_l  [0:6]  = '{3,5,7,9,15,21,35};
   longint cent_l [0:2] = '{64'd8400000, 64'd9000000, 64'd9600000};

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model_pick(input longint s, output int d, output int c);
      longint afe = s * 5;
      longint best = 60;
      d = 0; c = 0;
      for (int par = 0; par < 2; par++) begin
         for (int ci = 0; ci < 3; ci++) begin
            for (int j = 0; j < (par ? 7 : 36); j++) begin
               longint dv = par ? odd_l[j] : even_l[j];
               longint dc = dv * afe;
               longint cf = cent_l[ci];
               longint dev;
               if (dc > cf) begin
                  dev = 1000 * (dc - cf) / cf;
                  if (dev < 10 && dev < best) begin best = dev; d = int'(dv); c = ci; end
               end else begin
                  dev = 1000 * (cf - dc) / cf;
                  if (dev < best) begin best = dev; d = int'(dv); c = ci; end
               end
            end
         end
         if (d != 0) break;
      end
   endfunction

   function automatic void model_fac(input int d, output int p0, output int p1, output int p2);
      int h = d / 2;
      p0 = 1; p1 = 1; p2 = 1;
      if (d % 2 == 0) begin
         if (h == 1 || h == 2 || h == 3 || h == 5) begin p0 = 2; p2 = h; end
         else if (h % 2 == 0) begin p0 = 2; p1 = h / 2; p2 = 2; end
         else if (h % 3 == 0) begin p0 = 3; p1 = h / 3; p2 = 2; end
         else if (h % 7 == 0) begin p0 = 7; p1 = h / 7; p2 = 2; end
      end else if (d == 3 || d == 9) begin p0 = 3; p2 = d / 3; end
      else if (d == 5 || d == 7) p0 = d;
      else if (d == 15) begin p0 = 3; p2 = 5; end
      else if (d == 21) begin p0 = 7; p2 = 3; end
      else if (d == 35) begin p0 = 7; p2 = 5; end
   endfunction

   task automatic run_case(input int s, input string tag);
      int d, c, p0, p1, p2;
      longint dco, iw, a, fr;
      bit seen_i = 0, seen_f = 0;
      int n = 0;
      model_pick(s, d, c);
      @(negedge clk);
      sym = SYM_W'(s);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(i_busy == 1'b1, "R2 busy after start", i_busy, 1);
      while (!(seen_i && seen_f) && n < 5000) begin
         @(negedge clk);
         if (i_done) begin
            seen_i = 1;
            chk(!i_busy, "R2 busy low with done", i_busy, 0);
            chk(i_fail == (d == 0), "R6 fail flag", i_fail, d == 0);
         end
         if (f_done) seen_f = 1;
         n++;
      end
      chk(seen_i && seen_f, "R2 done seen", seen_i, 1);
      @(negedge clk);
      chk(!i_done, "R2 done one cycle", i_done, 0);
      chk(i_div == 7'(d), {tag, " divisor"}, i_div, d);
      chk({i_div, i_p0, i_p1, i_p2, i_men, i_cen, i_dco, i_int, i_frac} ==
          {f_div, f_p0, f_p1, f_p2, f_men, f_cen, f_dco, f_int, f_frac},
          "R12 variants agree", f_div, i_div);
      if (d == 0) begin
         chk(i_dco == 0 && i_p0 == 0 && i_int == 0, "R6 fields zero", i_dco, 0);
      end else begin
         model_fac(d, p0, p1, p2);
         dco = longint'(d) * 5 * s;
         iw = dco / 1000 / 24;
         a = dco * 32768 / 24;
         fr = (a - iw * 1000 * 32768) / 1000;
         chk({i_p0, i_p1, i_p2} == {3'(p0), 5'(p1), 3'(p2)},
             (d % 2 == 0) ? "R7 even ratios" : "R8 odd ratios", {i_p0, i_p1, i_p2}, {3'(p0), 5'(p1), 3'(p2)});
         chk(i_men == (p1 != 1), "R9 mid enable", i_men, p1 != 1);
         chk(i_cen == 2'(c), "R10 centre code", i_cen, c);
         chk(i_dco == DCO_W'(dco), "R10 dco kHz", i_dco, dco);
         chk(i_int == 10'(iw), "R11 integer word", i_int, iw);
         chk(i_frac == 15'(fr), "R11 fraction word", i_frac, fr);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!i_busy && !i_done && !i_fail && i_div == 0 && i_dco == 0, "R1 reset state", i_busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!i_busy && !i_done && i_frac == 0, "R1 idle after reset", i_busy, 0);
      run_case(148500, "R3");
      run_case(141300, "R4 above accepted");
      run_case(141400, "R4 above rejected");
      run_case(250000, "R5 odd 7");
      run_case(340000, "R5 odd 5");
      run_case(540000, "R5 odd 3");
      run_case(1048575, "R6 none high");
      run_case(1000, "R6 none low");
      run_case(25175, "R3");
      run_case(74250, "R3");
      for (int k = 0; k < 40; k++) begin
         run_case(20000 + int'($urandom % 700000), "R3 random");
      end
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule